// File: doc/BRIEF.md
# SPI Interrupt Status and Enable Logic

This block gathers the event sources of an SPI controller into one level-sensitive interrupt line. The receive FIFO supplies two level conditions: not empty, and full. The shift and FIFO logic supply four single-cycle events: receive overrun, transmit empty, transmit underrun and transmit half empty. Each source sets a sticky bit in a status register. That bit stays set until software clears it.

Software reaches three registers through decoded write strobes and a shared 32-bit write-data bus: the status register, a per-source enable register and a global enable register. Writes to the status register use a toggle (XOR) rule, not write-one-to-clear. The interrupt output is a flop driven by the status and enable registers, gated by the global enable.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the status, enable and global enable registers read 0 and `irq` is 0.
- R2: Each source sets its own status bit: transmit empty bit 2, transmit underrun bit 3, receive full bit 4, receive overrun bit 5, transmit half empty bit 6, receive not empty bit 8. The bit is visible on `stat_q` after the clock edge at which the source is high.
- R3: A status bit stays set after its source drops, for as long as no status write toggles it.
- R4: A status write XORs `wdata` into the stored bits. Writing 1 to a set bit clears it, and writing 1 to a clear bit sets it.
- R5: When a source is active in the same cycle as a status write that would clear its bit, the bit ends up set.
- R6: While `rx_not_empty` or `rx_full` is held high, an attempt to clear the matching bit (bit 8 or bit 4) leaves the bit set.
- R7: Status and enable bits other than 2, 3, 4, 5, 6 and 8 always read 0, and writes to them have no effect.
- R8: The global enable register keeps only bit 31; all its other bits read 0. While bit 31 is 0, `irq` is 0.
- R9: `irq` is registered. After each clock edge it equals the OR over (status AND enable), ANDed with global enable bit 31, where those register values are the ones held before that edge. It therefore trails a register change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_we | input | 1 | Status register write strobe (toggle rule) |
| ien_we | input | 1 | Enable register write strobe |
| gie_we | input | 1 | Global enable register write strobe |
| wdata | input | 32 | Write data for the three registers |
| rx_not_empty | input | 1 | Level: receive FIFO holds data |
| rx_full | input | 1 | Level: receive FIFO is full |
| rx_overrun | input | 1 | Pulse: received byte dropped |
| tx_empty | input | 1 | Pulse: transmit FIFO drained |
| tx_underrun | input | 1 | Pulse: transmit ran dry mid-transfer |
| tx_half_empty | input | 1 | Pulse: transmit FIFO at half level |
| stat_q | output | 32 | Status register contents |
| ien_q | output | 32 | Enable register contents |
| gie_q | output | 32 | Global enable register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The case that needs care is a hardware event landing in the same cycle as a software toggle of its own status bit. Directed steps raise an underrun pulse, or hold the receive-not-empty level, in the very cycle a write of 1 targets that set bit; the bench then expects the bit to read 1 afterwards. Random phases drive events and all three write strobes together at high rates, so these collisions recur across every bit. A bench model applies the set-wins-over-toggle rule and judges each collision on `stat_q` and, one cycle later, on `irq`.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned NUM_SRC = 6;
   localparam int unsigned POS_TX_EMPTY     = 2;
   localparam int unsigned POS_TX_UNDERRUN  = 3;
   localparam int unsigned POS_RX_FULL      = 4;
   localparam int unsigned POS_RX_OVERRUN   = 5;
   localparam int unsigned POS_TX_HALF      = 6;
   localparam int unsigned POS_RX_NOT_EMPTY = 8;

   function automatic int unsigned src_pos(input int unsigned idx);
      case (idx)
         0: return POS_TX_EMPTY;
         1: return POS_TX_UNDERRUN;
         2: return POS_RX_FULL;
         3: return POS_RX_OVERRUN;
         4: return POS_TX_HALF;
         default: return POS_RX_NOT_EMPTY;
      endcase
   endfunction

   function automatic logic [31:0] defined_mask();
      logic [31:0] m;
      m = '0;
      for (int unsigned k = 0; k < NUM_SRC; k++) m[src_pos(k)] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] hw_set,
   output logic [DATA_W-1:0] stat_q
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'(defined_mask());

   logic [DATA_W-1:0] toggled;
   logic [DATA_W-1:0] stat_d;

   always_comb begin
      toggled = we ? (stat_q ^ wdata) : stat_q;
      stat_d  = (toggled | hw_set) & MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   // R3: without a write no set bit drops
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   // R5: a hardware set always lands, even against a toggle
   p_hw_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ($past(hw_set) & MASK)) == ($past(hw_set) & MASK)));
   // R4: write with no hardware set toggles the written bits
   p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hw_set == '0) |=> (stat_q == (($past(stat_q) ^ $past(wdata)) & MASK)));
   // R7: undefined bits stay zero
   p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~MASK) == '0);
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned GIE_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_we,
   input  logic              gie_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ien_q,
   output logic              gie_bit
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'(defined_mask());

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= '0;
         gie_bit <= 1'b0;
      end else begin
         if (ien_we) ien_q   <= wdata & MASK;
         if (gie_we) gie_bit <= wdata[GIE_BIT];
      end
   end

   // R7: enable never holds undefined bits
   p_ien_defined_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q & ~MASK) == '0);
   // R8: global enable only moves on its strobe
   p_gie_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_we |=> $stable(gie_bit));
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] ien_q,
   input  logic              gie_bit,
   output logic              irq
);
   logic pend;

   always_comb pend = (|(stat_q & ien_q)) & gie_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= pend;
   end

   // R8: global enable off forces the line low next cycle
   p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_bit |=> !irq);
   // R9: nothing enabled means no request next cycle
   p_no_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ien_q) == '0) |=> !irq);
   // R9: an enabled pending bit under global enable raises the line
   p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_bit && (stat_q & ien_q) != '0) |=> irq);
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned GIE_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic              ien_we,
   input  logic              gie_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_not_empty,
   input  logic              rx_full,
   input  logic              rx_overrun,
   input  logic              tx_empty,
   input  logic              tx_underrun,
   input  logic              tx_half_empty,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] ien_q,
   output logic [DATA_W-1:0] gie_q,
   output logic              irq
);
   initial begin
      if (GIE_BIT >= DATA_W) $error("GIE_BIT must lie inside DATA_W");
      if (DATA_W <= POS_RX_NOT_EMPTY) $error("DATA_W too narrow for status layout");
   end

   logic [NUM_SRC-1:0] src_vec;
   logic [DATA_W-1:0]  hw_set;
   logic               gie_bit;

   assign src_vec = {rx_not_empty, tx_half_empty, rx_overrun, rx_full, tx_underrun, tx_empty};

   for (genvar g = 0; g < DATA_W; g++) begin : g_map
      if (g == POS_TX_EMPTY)          begin : g_s0 assign hw_set[g] = src_vec[0]; end
      else if (g == POS_TX_UNDERRUN)  begin : g_s1 assign hw_set[g] = src_vec[1]; end
      else if (g == POS_RX_FULL)      begin : g_s2 assign hw_set[g] = src_vec[2]; end
      else if (g == POS_RX_OVERRUN)   begin : g_s3 assign hw_set[g] = src_vec[3]; end
      else if (g == POS_TX_HALF)      begin : g_s4 assign hw_set[g] = src_vec[4]; end
      else if (g == POS_RX_NOT_EMPTY) begin : g_s5 assign hw_set[g] = src_vec[5]; end
      else                            begin : g_nn assign hw_set[g] = 1'b0; end
   end

   irq_status_reg #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .we(stat_we), .wdata(wdata),
      .hw_set(hw_set), .stat_q(stat_q));

   irq_enable_regs #(.DATA_W(DATA_W), .GIE_BIT(GIE_BIT)) u_en (
      .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .gie_we(gie_we),
      .wdata(wdata), .ien_q(ien_q), .gie_bit(gie_bit));

   irq_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .ien_q(ien_q),
      .gie_bit(gie_bit), .irq(irq));

   always_comb begin
      gie_q = '0;
      gie_q[GIE_BIT] = gie_bit;
   end

   // R6: a held receive level keeps its bit set
   p_level_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_not_empty |=> stat_q[POS_RX_NOT_EMPTY]);
   // R2: each pulse source shows at its position
   p_overrun_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> stat_q[POS_RX_OVERRUN]);
endmodule

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;
   localparam logic [31:0] MASK = 32'h0000_017C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stat_we = 0, ien_we = 0, gie_we = 0;
   logic [31:0] wdata = '0;
   logic        rx_not_empty = 0, rx_full = 0, rx_overrun = 0;
   logic        tx_empty = 0, tx_underrun = 0, tx_half_empty = 0;
   logic [31:0] stat_q, ien_q, gie_q;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_stat = '0, m_ien = '0, m_gie = '0;
   logic        m_irq = 1'b0;

   spi_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .ien_we(ien_we), .gie_we(gie_we),
      .wdata(wdata), .rx_not_empty(rx_not_empty), .rx_full(rx_full),
      .rx_overrun(rx_overrun), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
      .tx_half_empty(tx_half_empty), .stat_q(stat_q), .ien_q(ien_q),
      .gie_q(gie_q), .irq(irq));

   always #5 clk = ~clk;

   function automatic logic [31:0] hw_vec();
      logic [31:0] v = '0;
      v[2] = tx_empty; v[3] = tx_underrun; v[4] = rx_full;
      v[5] = rx_overrun; v[6] = tx_half_empty; v[8] = rx_not_empty;
      return v;
   endfunction

   function automatic logic [31:0] next_stat();
      logic [31:0] t = stat_we ? (m_stat ^ wdata) : m_stat;
      return (t | hw_vec()) & MASK;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: model follows the requirements, sample at the next falling edge
   task automatic cyc();
      logic [31:0] ns, ni, ng;
      logic        nirq;
      ns   = next_stat();
      ni   = ien_we ? (wdata & MASK) : m_ien;
      ng   = gie_we ? (wdata & 32'h8000_0000) : m_gie;
      nirq = (|(m_stat & m_ien)) & m_gie[31];
      @(negedge clk);
      m_stat = ns; m_ien = ni; m_gie = ng; m_irq = nirq;
   endtask

   task automatic idle();
      stat_we = 0; ien_we = 0; gie_we = 0; wdata = '0;
      rx_not_empty = 0; rx_full = 0; rx_overrun = 0;
      tx_empty = 0; tx_underrun = 0; tx_half_empty = 0;
   endtask

   task automatic check_all(input string req);
      chk(req, stat_q, m_stat);
      chk(req, ien_q, m_ien);
      chk(req, gie_q, m_gie);
      chk(req, {31'b0, irq}, {31'b0, m_irq});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 stat", stat_q, 32'h0); chk("R1 ien", ien_q, 32'h0);
      chk("R1 gie", gie_q, 32'h0);   chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 each source at its position
      tx_empty = 1; cyc(); idle(); chk("R2 tx_empty bit2", stat_q, 32'h004);
      cyc(); chk("R3 sticky bit2", stat_q, 32'h004);
      stat_we = 1; wdata = 32'h004; cyc(); idle(); chk("R4 clear bit2", stat_q, 32'h0);
      tx_underrun = 1; cyc(); idle(); chk("R2 underrun bit3", stat_q, 32'h008);
      rx_full = 1; cyc(); idle(); chk("R2 rx_full bit4", stat_q, 32'h018);
      rx_overrun = 1; cyc(); idle(); chk("R2 overrun bit5", stat_q, 32'h038);
      tx_half_empty = 1; cyc(); idle(); chk("R2 half bit6", stat_q, 32'h078);
      rx_not_empty = 1; cyc(); idle(); chk("R2 rx_ne bit8", stat_q, 32'h178);
      // R5 hardware set against clearing toggle of bit 3
      tx_underrun = 1; stat_we = 1; wdata = 32'h008; cyc(); idle();
      chk("R5 set wins bit3", stat_q, 32'h178);
      // R6 held level defeats clear of bit 8 and bit 4
      rx_not_empty = 1; rx_full = 1; stat_we = 1; wdata = 32'h110; cyc();
      chk("R6 level rearm", stat_q, 32'h178);
      stat_we = 0; cyc(); idle();
      // R4 clear all then toggle-set bit 8
      stat_we = 1; wdata = 32'h178; cyc(); idle(); chk("R4 clear all", stat_q, 32'h0);
      stat_we = 1; wdata = 32'h100; cyc(); idle(); chk("R4 toggle sets", stat_q, 32'h100);
      // R7 undefined bits
      stat_we = 1; wdata = 32'hFFFF_FE83; cyc(); idle(); chk("R7 stat undef", stat_q, 32'h100);
      ien_we = 1; wdata = 32'hFFFF_FFFF; cyc(); idle(); chk("R7 ien undef", ien_q, 32'h17C);
      // R8 global enable off keeps irq low
      cyc(); chk("R8 irq gated", {31'b0, irq}, 32'h0);
      gie_we = 1; wdata = 32'hFFFF_FFFF; cyc(); idle();
      chk("R8 gie bit31 only", gie_q, 32'h8000_0000);
      chk("R9 one-cycle lag", {31'b0, irq}, 32'h0);
      cyc(); chk("R9 irq high", {31'b0, irq}, 32'h1);
      stat_we = 1; wdata = 32'h100; cyc(); idle();
      chk("R9 irq still high", {31'b0, irq}, 32'h1);
      cyc(); chk("R9 irq drops", {31'b0, irq}, 32'h0);

      // random phase: R2 R3 R4 R5 R6 R7 R8 R9 against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         stat_we = r[0] & r[1]; ien_we = (r[2:4] == 3'b000); gie_we = (r[5:7] == 3'b000);
         wdata = $urandom;
         if (r[8]) wdata = wdata & MASK;
         tx_empty = r[9] & r[10]; tx_underrun = r[11] & r[12]; rx_full = r[13] & r[14];
         rx_overrun = r[15] & r[16]; tx_half_empty = r[17] & r[18]; rx_not_empty = r[19];
         cyc();
         check_all("R2 R4 R5 R9 random");
      end
      idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule